// File: doc/BRIEF.md
# Serial Command Frame Decoder for a Quad Digital Potentiometer

This block is the slave-side serial front end of a four-channel digital potentiometer controller. It oversamples the serial clock, chip select, data input and pause input in the system clock domain. It takes a data bit on every rising serial clock and drives the serial output on every falling one. Each frame opens with an identification byte, which must carry the fixed device type and the two strap address bits. The instruction byte that follows is split into an opcode, a register index and a pot index.

Depending on the opcode, the frame ends after the instruction byte (transfers), carries a third byte (reads, writes and status), or stays open, so that every further clock pulse steps the selected wiper up or down. The block reports each decoded command to the register bank and the wiper counters as a single-cycle strobe with its fields. Each wiper step is reported as a separate single-cycle strobe with a direction bit.

The serial clock's half period is assumed to be at least four system clocks. The strobes lag the pins by three system clocks.

Top module: `spi_pot_frontend`

## Requirements
- R1: The first byte after chip select falls, taken MSB first, must equal 0101, then 00, then the strap pins (addr_strap[1], addr_strap[0]). On any mismatch, the rest of the frame produces no strobe until chip select rises.
- R2: In the instruction byte, bits 7:4 are reported on cmd_op, bits 3:2 on cmd_reg and bits 1:0 on cmd_pot.
- R3: Transfer opcodes 1101 (data register to wiper), 1110 (wiper to data register), 0001 (global data register to wiper) and 1000 (global wiper to data register) give one cmd_valid pulse at the end of the instruction byte, with cmd_data zero.
- R4: Write opcodes 1010 (wiper) and 1100 (data register) give one cmd_valid pulse at the end of the third byte, with cmd_data equal to that byte's low six bits. Every other strobe carries cmd_data zero.
- R5: Read opcodes 1001 (wiper) and 1011 (data register) give one cmd_valid pulse at the end of the instruction byte. rd_data is sampled one clock after that pulse. During the third byte, so returns {00, rd_data} MSB first, and it changes only after a falling serial clock.
- R6: Read status, opcode 0101, behaves like a read, but the returned byte is seven zeros followed by wip in bit 0.
- R7: After opcode 0010, every rising serial clock gives one step_valid pulse until chip select rises. step_up equals the data bit sampled on that edge, and cmd_pot holds the selected pot.
- R8: Any opcode not listed in R3 to R7 produces no strobe for the rest of the frame.
- R9: so_oe is low while chip select is high and at all times before the first frame. It is high while a frame is selected.
- R10: While hold_n is low, serial clock edges are ignored and the frame's partial state is kept. The frame carries on after hold_n returns high. No step is issued during a hold.
- R11: After reset, nothing is accepted until chip select has been seen high and has then fallen.
- R12: cmd_valid lasts one clock, and cmd_valid and step_valid are never high together.
- R13: When chip select rises in the middle of a frame, the partial bits are discarded, and the next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| addr_strap | input | 2 | Strap address compared with the identification byte |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| rd_data | input | 6 | Value of the selected register, returned by the bank |
| wip | input | 1 | Internal write in progress flag |
| cmd_valid | output | 1 | Single-cycle command strobe |
| cmd_op | output | 4 | Opcode of the strobed command |
| cmd_reg | output | 2 | Register index |
| cmd_pot | output | 2 | Pot index, also held during stepping |
| cmd_data | output | 6 | Write data |
| step_valid | output | 1 | Single-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 toward the high terminal |

## Verification
The bench goes after identification bytes that are wrong in only one field: the type nibble, the two zero bits or the address. A decoder that checked only part of the byte would then issue strobes for another device. It pauses a frame in the middle of the instruction byte while clocking extra pulses. A pause that fails to freeze the shifter would scramble the pot and register fields. It drops chip select in the middle of a byte and then sends a clean frame. It also holds chip select low through reset, where a decoder that treats the reset level as a falling edge would accept a command. Step frames with mixed directions and a paused stretch expose wrong step counts, and read-back bytes expose an output that shifts on the wrong edge or one bit early.

// File: rtl/spi_pot_pkg.sv
// Shared opcodes, frame states and opcode classification for the
// potentiometer serial front end.
package spi_pot_pkg;

    localparam logic [3:0] OP_RD_WIPER  = 4'b1001;
    localparam logic [3:0] OP_WR_WIPER  = 4'b1010;
    localparam logic [3:0] OP_RD_DREG   = 4'b1011;
    localparam logic [3:0] OP_WR_DREG   = 4'b1100;
    localparam logic [3:0] OP_DREG2WIP  = 4'b1101;
    localparam logic [3:0] OP_WIP2DREG  = 4'b1110;
    localparam logic [3:0] OP_ALL_D2W   = 4'b0001;
    localparam logic [3:0] OP_ALL_W2D   = 4'b1000;
    localparam logic [3:0] OP_STEP      = 4'b0010;
    localparam logic [3:0] OP_STATUS    = 4'b0101;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ID,
        FS_INS,
        FS_DATA,
        FS_STEP,
        FS_DONE
    } frame_st_t;

    // Transfer opcodes end with the instruction byte.
    function automatic logic op_is_xfer(input logic [3:0] op);
        return (op == OP_DREG2WIP) || (op == OP_WIP2DREG) ||
               (op == OP_ALL_D2W)  || (op == OP_ALL_W2D);
    endfunction

    // Opcodes that return a byte on so.
    function automatic logic op_is_read(input logic [3:0] op);
        return (op == OP_RD_WIPER) || (op == OP_RD_DREG) || (op == OP_STATUS);
    endfunction

    // Opcodes that take a data byte from the host.
    function automatic logic op_is_write(input logic [3:0] op);
        return (op == OP_WR_WIPER) || (op == OP_WR_DREG);
    endfunction

endpackage

// File: rtl/spi_pot_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes every bit is a slow level that may be sampled on its own.
// All stages reset to zero.
module spi_pot_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Shift the inputs through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_pot_edge.sv
// Per-bit rise and fall detector for synchronised levels.
// Assumes the inputs are already in the clk domain.
// The history register resets to zero.
module spi_pot_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign rise[g] = lvl[g] & ~prev[g];
        assign fall[g] = ~lvl[g] & prev[g];
    end

endmodule

// File: rtl/spi_pot_frontend.sv
// Serial front end of a quad digital potentiometer controller.
// It oversamples the serial pins, checks the identification byte, decodes
// the instruction byte and runs two-byte, three-byte and open-ended step
// frames. Commands leave as single-cycle strobes.
// Assumes the serial clock half period is at least four clk cycles.
module spi_pot_frontend
    import spi_pot_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         VAL_W       = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             si,
    input  logic             hold_n,
    input  logic [1:0]       addr_strap,
    output logic             so,
    output logic             so_oe,
    input  logic [VAL_W-1:0] rd_data,
    input  logic             wip,
    output logic             cmd_valid,
    output logic [3:0]       cmd_op,
    output logic [1:0]       cmd_reg,
    output logic [1:0]       cmd_pot,
    output logic [VAL_W-1:0] cmd_data,
    output logic             step_valid,
    output logic             step_up
);

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam int IDX_SCK  = 0;
    localparam int IDX_CS   = 1;
    localparam int IDX_SI   = 2;
    localparam int IDX_HOLD = 3;

    logic [3:0] pins_s;
    logic [1:0] edge_rise, edge_fall;
    logic       sck_s, cs_s, si_s, hold_s;
    logic       bit_rise, bit_fall;

    spi_pot_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hold_n, si, cs_n, sck}),
        .q(pins_s)
    );

    assign sck_s  = pins_s[IDX_SCK];
    assign cs_s   = pins_s[IDX_CS];
    assign si_s   = pins_s[IDX_SI];
    assign hold_s = pins_s[IDX_HOLD];

    spi_pot_edge #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl({cs_s, sck_s}),
        .rise(edge_rise),
        .fall(edge_fall)
    );

    // Serial clock edges count only while selected and not paused.
    assign bit_rise = edge_rise[0] & hold_s & ~cs_s;
    assign bit_fall = edge_fall[0] & hold_s & ~cs_s;

    frame_st_t            st;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_W-2:0]    shreg;
    logic [BYTE_W-1:0]    tx;
    logic [BYTE_W-1:0]    nxt;
    logic [3:0]           nxt_op;
    logic                 armed;
    logic                 load_pend;
    logic                 so_q, oe_q;

    assign nxt    = {shreg, si_s};
    assign nxt_op = nxt[BYTE_W-1 -: 4];

    // Frame sequencing, byte assembly, strobes and the output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= FS_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            tx         <= '0;
            armed      <= 1'b0;
            load_pend  <= 1'b0;
            so_q       <= 1'b0;
            oe_q       <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_op     <= '0;
            cmd_reg    <= '0;
            cmd_pot    <= '0;
            cmd_data   <= '0;
            step_valid <= 1'b0;
            step_up    <= 1'b0;
        end else begin
            cmd_valid  <= 1'b0;
            step_valid <= 1'b0;
            load_pend  <= 1'b0;
            oe_q       <= armed & ~cs_s;
            if (edge_rise[1]) armed <= 1'b1;
            if (cs_s) begin
                st <= FS_IDLE;
            end else if (edge_fall[1] && armed) begin
                st  <= FS_ID;
                cnt <= '0;
            end else begin
                if (load_pend) begin
                    tx <= (cmd_op == OP_STATUS) ? {{(BYTE_W-1){1'b0}}, wip}
                                                : {{(BYTE_W-VAL_W){1'b0}}, rd_data};
                end
                if (bit_rise && (st == FS_ID || st == FS_INS || st == FS_DATA)) begin
                    shreg <= nxt[BYTE_W-2:0];
                    cnt   <= cnt + 1'b1;
                end
                unique case (st)
                    FS_ID: begin
                        if (bit_rise && cnt == LAST_BIT)
                            st <= (nxt == {DEV_TYPE, 2'b00, addr_strap}) ? FS_INS : FS_DONE;
                    end
                    FS_INS: begin
                        if (bit_rise && cnt == LAST_BIT) begin
                            cmd_op   <= nxt_op;
                            cmd_reg  <= nxt[3:2];
                            cmd_pot  <= nxt[1:0];
                            cmd_data <= '0;
                            if (op_is_xfer(nxt_op)) begin
                                cmd_valid <= 1'b1;
                                st        <= FS_DONE;
                            end else if (op_is_read(nxt_op)) begin
                                cmd_valid <= 1'b1;
                                load_pend <= 1'b1;
                                st        <= FS_DATA;
                            end else if (op_is_write(nxt_op)) begin
                                st <= FS_DATA;
                            end else if (nxt_op == OP_STEP) begin
                                st <= FS_STEP;
                            end else begin
                                st <= FS_DONE;
                            end
                        end
                    end
                    FS_DATA: begin
                        if (bit_fall) begin
                            so_q <= tx[BYTE_W-1];
                            tx   <= {tx[BYTE_W-2:0], 1'b0};
                        end
                        if (bit_rise && cnt == LAST_BIT) begin
                            if (op_is_write(cmd_op)) begin
                                cmd_valid <= 1'b1;
                                cmd_data  <= nxt[VAL_W-1:0];
                            end
                            st <= FS_DONE;
                        end
                    end
                    FS_STEP: begin
                        if (bit_rise) begin
                            step_valid <= 1'b1;
                            step_up    <= si_s;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign so    = so_q;
    assign so_oe = oe_q;

endmodule

// File: rtl/spi_pot_frontend_chk.sv
// Temporal checks on the ports of spi_pot_frontend, attached with bind.
// The pin-to-output lag is three clk cycles (two sync stages plus one register).
module spi_pot_frontend_chk
    import spi_pot_pkg::*;
#(
    parameter int VAL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             hold_n,
    input logic             so_oe,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [VAL_W-1:0] cmd_data,
    input logic             step_valid
);

    logic seen_hi, seen_fall;

    // Track whether chip select has been high and then low since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_hi   <= 1'b0;
            seen_fall <= 1'b0;
        end else begin
            seen_hi   <= seen_hi | cs_n;
            seen_fall <= seen_fall | (seen_hi & ~cs_n);
        end
    end

    a_r12_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && step_valid));

    a_r9_so_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, 3) |-> !so_oe);

    a_r8_known_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (op_is_xfer(cmd_op) || op_is_read(cmd_op) || op_is_write(cmd_op)));

    a_r4_data_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !op_is_write(cmd_op)) |-> (cmd_data == '0));

    a_r11_quiet_until_select: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_fall |-> (!cmd_valid && !step_valid));

    a_r7_step_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> !$past(cs_n, 3));

    a_r10_no_step_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> $past(hold_n, 3));

endmodule

bind spi_pot_frontend spi_pot_frontend_chk #(.VAL_W(VAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_oe(so_oe),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .step_valid(step_valid)
);

// File: tb/tb_spi_pot_frontend.sv
// Self-checking bench: a vector table of frames, then directed corner cases.
module tb_spi_pot_frontend;

    localparam int HALF = 6;
    localparam int NV   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [1:0] addr_strap = 2'b10;
    logic [5:0] rd_data = 6'h2B;
    logic       wip = 1'b1;
    logic       so, so_oe, cmd_valid, step_valid, step_up;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg, cmd_pot;
    logic [5:0] cmd_data;

    int checks = 0, errors = 0;
    int n_cmd = 0, n_step = 0, n_up = 0;
    logic [3:0] l_op;
    logic [1:0] l_reg, l_pot, s_pot;
    logic [5:0] l_data;

    localparam logic [7:0] ID_OK = 8'b0101_0010;

    // Frame vectors: instruction, data byte, byte count, strobes, read-back
    localparam logic [7:0] V_INS [NV] = '{8'hA2, 8'hCD, 8'h93, 8'hB8, 8'h50,
                                         8'hD6, 8'hE9, 8'h1C, 8'h80, 8'h70};
    localparam logic [7:0] V_DAT [NV] = '{8'hFF, 8'h15, 8'h00, 8'h00, 8'h00,
                                         8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    localparam int         V_LEN [NV] = '{3, 3, 3, 3, 3, 2, 2, 2, 2, 2};
    localparam int         V_NS  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
    localparam logic [7:0] V_RD  [NV] = '{8'h00, 8'h00, 8'h2B, 8'h2B, 8'h01,
                                         8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

    always #10 clk = ~clk;

    spi_pot_frontend dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .addr_strap(addr_strap), .so(so), .so_oe(so_oe),
        .rd_data(rd_data), .wip(wip), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_pot(cmd_pot), .cmd_data(cmd_data),
        .step_valid(step_valid), .step_up(step_up)
    );

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (cmd_valid) begin
            n_cmd  = n_cmd + 1;
            l_op   = cmd_op;
            l_reg  = cmd_reg;
            l_pot  = cmd_pot;
            l_data = cmd_data;
        end
        if (step_valid) begin
            n_step = n_step + 1;
            if (step_up) n_up = n_up + 1;
            s_pot = cmd_pot;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        si = b;
        wclk(HALF);
        smp = so;
        sck = 1'b1;
        wclk(HALF);
        sck = 1'b0;
        wclk(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r[i]);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        wclk(HALF);
    endtask

    initial begin
        wclk(200000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       b;
        int         base, sbase, ubase;
        // Chip select held low through reset (R11)
        wclk(5);
        rst_n = 1'b1;
        wclk(4);
        check("R9 reset so_oe", int'(so_oe), 0);
        check("R11 reset no strobe", n_cmd, 0);
        send_byte(ID_OK, r);
        send_byte(8'hD1, r);
        check("R11 no command before first select", n_cmd, 0);
        check("R9 so_oe off before first frame", int'(so_oe), 0);
        cs_hi();

        // Vector table
        for (int v = 0; v < NV; v++) begin
            base = n_cmd;
            cs_lo();
            send_byte(ID_OK, r);
            send_byte(V_INS[v], r);
            if (v == 0) check("R9 so_oe on while selected", int'(so_oe), 1);
            if (V_LEN[v] == 3) send_byte(V_DAT[v], r);
            cs_hi();
            check($sformatf("R3/R4/R5/R8 strobe count vec %0d", v), n_cmd - base, V_NS[v]);
            if (V_NS[v] == 1) begin
                check("R2 opcode field", int'(l_op), int'(V_INS[v][7:4]));
                check("R2 register field", int'(l_reg), int'(V_INS[v][3:2]));
                check("R2 pot field", int'(l_pot), int'(V_INS[v][1:0]));
                if (V_INS[v][7:4] == 4'b1010 || V_INS[v][7:4] == 4'b1100)
                    check("R4 write data", int'(l_data), int'(V_DAT[v][5:0]));
                else
                    check("R3 cmd_data zero", int'(l_data), 0);
            end
            if (V_INS[v][7:4] == 4'b0101)
                check("R6 status read-back", int'(r), int'(V_RD[v]));
            else if (V_INS[v][7:4] == 4'b1001 || V_INS[v][7:4] == 4'b1011)
                check("R5 read-back byte", int'(r), int'(V_RD[v]));
        end
        check("R9 so_oe off after deselect", int'(so_oe), 0);

        // R1: identification byte wrong in one field at a time
        base = n_cmd;
        cs_lo(); send_byte(8'b0101_0001, r); send_byte(8'hD0, r); cs_hi();
        cs_lo(); send_byte(8'b0111_0010, r); send_byte(8'hD0, r); cs_hi();
        cs_lo(); send_byte(8'b0101_0110, r); send_byte(8'hD0, r); cs_hi();
        check("R1 bad identification ignored", n_cmd - base, 0);

        // R13: abort in the middle of a byte, then a clean frame
        base = n_cmd;
        cs_lo();
        clk_bit(1'b1, b); clk_bit(1'b1, b); clk_bit(1'b0, b);
        cs_hi();
        cs_lo(); send_byte(ID_OK, r); send_byte(8'hE6, r); cs_hi();
        check("R13 fresh frame after abort", n_cmd - base, 1);
        check("R13 fresh frame op", int'(l_op), 14);
        check("R13 fresh frame pot", int'(l_pot), 2);

        // R10: hold in the middle of the instruction byte
        base = n_cmd;
        cs_lo();
        send_byte(ID_OK, r);
        clk_bit(1'b1, b); clk_bit(1'b1, b); clk_bit(1'b0, b); clk_bit(1'b1, b);
        hold_n = 1'b0;
        wclk(HALF);
        clk_bit(1'b0, b); clk_bit(1'b0, b); clk_bit(1'b1, b);
        hold_n = 1'b1;
        wclk(HALF);
        clk_bit(1'b0, b); clk_bit(1'b1, b); clk_bit(1'b1, b); clk_bit(1'b1, b);
        cs_hi();
        check("R10 frame survives hold", n_cmd - base, 1);
        check("R10 register field after hold", int'(l_reg), 1);
        check("R10 pot field after hold", int'(l_pot), 3);

        // R7: open-ended stepping, with a paused stretch (R10)
        sbase = n_step;
        ubase = n_up;
        cs_lo();
        send_byte(ID_OK, r);
        send_byte(8'h21, r);
        clk_bit(1'b1, b); clk_bit(1'b1, b); clk_bit(1'b0, b);
        hold_n = 1'b0;
        wclk(HALF);
        clk_bit(1'b1, b); clk_bit(1'b1, b);
        check("R10 no step during hold", n_step - sbase, 3);
        hold_n = 1'b1;
        wclk(HALF);
        clk_bit(1'b1, b); clk_bit(1'b0, b);
        cs_hi();
        clk_bit(1'b1, b);
        check("R7 step count", n_step - sbase, 5);
        check("R7 up steps", n_up - ubase, 3);
        check("R7 step pot", int'(s_pot), 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule